// File: doc/BRIEF.md
# Eight-Input Interrupt Controller

This block gathers eight interrupt request lines into one interrupt signal for a processor. Each line senses either a rising edge or a high level, chosen per line. Three sets of state are kept apart: the pending requests, a mask that hides chosen lines, and the lines whose handlers are running (the in-service set). A fixed-priority resolver selects the request to present. Line 0 is the most urgent and line 7 the least urgent. A request is presented only if no line of equal or higher priority is in service.

Software reaches the block through a small write port. The port loads the mask, the per-line sense mode and the vector base, and it accepts non-specific end-of-interrupt commands. The processor answers the interrupt with two acknowledge pulses. The first pulse moves the winning request into the in-service set. The second pulse returns an 8-bit vector on `vec_out`, marked by a one-cycle `vec_valid` pulse. The processor paces every transfer through its own acknowledge pulses, so the vector output has no ready signal and no back-pressure.

Top module: `irq_merge8`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low. All lines are masked and in edge mode, the vector base is 0 and the in-service set is empty.
- R2: A line in edge mode (mode bit 0) latches a request on a rising input. The request stays pending after the input falls, until a first acknowledge takes it.
- R3: A line in level mode (mode bit 1) is pending only while its input is high. Dropping the input before acknowledge withdraws the request.
- R4: A masked line (mask bit 1) never raises `int_out`. An edge that arrives while the line is masked is still latched, and it is presented once the line is unmasked.
- R5: When several unmasked requests are pending, the lowest line number wins.
- R6: `int_out` is high exactly when an unmasked pending request has a lower line number than every in-service line. A request at or below the priority of an in-service line is held back.
- R7: A first acknowledge pulse while `int_out` is high sets the winner's in-service bit and clears its edge latch.
- R8: The second acknowledge pulse gives, one cycle later, a single-cycle `vec_valid`. `vec_out[7:3]` carries the vector base and `vec_out[2:0]` the line number taken at the first pulse.
- R9: A non-specific end-of-interrupt command clears only the lowest-numbered set bit of the in-service set.
- R10: A first acknowledge with no eligible request leaves the in-service set unchanged. The following second pulse returns line number 7 with the current base.
- R11: Register writes (`reg_wr` high) decode `reg_addr` as follows:
  - 0 writes the mask, with bit i for line i.
  - 1 writes the mode, with bit i for line i.
  - 2 loads the base from `reg_wdata[7:3]`.
  - 3 issues an end-of-interrupt, and the data is ignored.

  A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, bit i is line i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 mask, 1 mode, 2 base, 3 end-of-interrupt) |
| reg_wdata | input | 8 | Register write data |
| ack_in | input | 1 | Acknowledge pulse, alternating first and second |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle marker for `vec_out` |
| vec_out | output | 8 | Vector: base in bits 7:3, line number in bits 2:0 |

## Verification
A directed sequence covers the following cases:
- A single edge that arrives while masked, which separates latching from presenting.
- Two simultaneous edges, which shows that the lower line number wins.
- A higher-priority edge arriving while a lower line is in service, which separates nesting from blocking.
- Stacked end-of-interrupt commands, which show that only the top in-service bit is cleared.
- A level pulse that is withdrawn before acknowledge.
- A spurious acknowledge.

After that, seeded random toggling of lines, acknowledges, end-of-interrupt commands, mask and mode writes is compared cycle by cycle with a reference model. This exposes mistakes in priority order, in the blocking comparison and in the hand-off between the edge latches and the in-service set.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned VEC_BITS = 8;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_MODE = 2'd1,
    SEL_BASE = 2'd2,
    SEL_EOI  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqm_first.sv
module irqm_first #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |bits;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqm_line.sv
module irqm_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic level_mode,
  input  logic clr,
  output logic pending
);
  logic irq_q;
  logic latch_q;
  logic rise;

  assign rise = irq & ~irq_q & ~level_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      irq_q   <= irq;
      latch_q <= (latch_q & ~clr) | rise;
    end
  end

  assign pending = level_mode ? irq_q : latch_q;

  // R2
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr && !level_mode) |=> latch_q);
endmodule

// File: rtl/irqm_regs.sv
module irqm_regs #(
  parameter int unsigned N      = irqm_pkg::LINES,
  parameter int unsigned BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      mode_q,
  output logic [BASE_W-1:0] base_q,
  output logic              eoi
);
  import irqm_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);
  assign eoi = wr && (sel == SEL_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= '0;
      base_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MASK: mask_q <= wdata;
        SEL_MODE: mode_q <= wdata;
        SEL_BASE: base_q <= wdata[N-1 -: BASE_W];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irqm_service.sv
module irqm_service #(
  parameter int unsigned N      = irqm_pkg::LINES,
  parameter int unsigned IDX_W  = $clog2(N),
  parameter int unsigned BASE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ack,
  input  logic                    eoi,
  input  logic [N-1:0]            eligible,
  input  logic [BASE_W-1:0]       base,
  output logic                    int_req,
  output logic [N-1:0]            take,
  output logic                    vec_valid,
  output logic [BASE_W+IDX_W-1:0] vec
);
  logic [N-1:0]     isr_q;
  logic [N-1:0]     eoi_clr;
  logic             cand_found;
  logic [IDX_W-1:0] cand_idx;
  logic             top_found;
  logic [IDX_W-1:0] top_idx;
  logic             phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             first_ack;
  logic             second_ack;

  irqm_first #(.N(N), .IDX_W(IDX_W)) u_cand (
    .bits(eligible), .found(cand_found), .idx(cand_idx));

  irqm_first #(.N(N), .IDX_W(IDX_W)) u_top (
    .bits(isr_q), .found(top_found), .idx(top_idx));

  assign int_req    = cand_found && (!top_found || (cand_idx < top_idx));
  assign first_ack  = ack && !phase_q;
  assign second_ack = ack && phase_q;

  always_comb begin
    take = '0;
    if (first_ack && int_req) take[cand_idx] = 1'b1;
    eoi_clr = '0;
    if (eoi && top_found) eoi_clr[top_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q     <= '0;
      phase_q   <= 1'b0;
      idx_q     <= '0;
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      isr_q     <= (isr_q & ~eoi_clr) | take;
      vec_valid <= second_ack;
      if (ack) phase_q <= ~phase_q;
      if (first_ack) idx_q <= int_req ? cand_idx : '1;
      if (second_ack) vec <= {base, idx_q};
    end
  end

  // R7
  take_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && int_req) |=> isr_q[$past(cand_idx)]);

  // R8
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  // R9
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && top_found && !first_ack) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));

  // R10
  spurious_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && !int_req && !eoi) |=> (isr_q == $past(isr_q)));
endmodule

// File: rtl/irq_merge8.sv
module irq_merge8 #(
  parameter int unsigned N_LINES = irqm_pkg::LINES,
  parameter int unsigned VEC_W   = irqm_pkg::VEC_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  input  logic               ack_in,
  output logic               int_out,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out
);
  localparam int unsigned IDX_W  = $clog2(N_LINES);
  localparam int unsigned BASE_W = VEC_W - IDX_W;

  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] mode_q;
  logic [BASE_W-1:0]  base_q;
  logic               eoi;
  logic [N_LINES-1:0] pending;
  logic [N_LINES-1:0] take;
  logic [N_LINES-1:0] eligible;

  irqm_regs #(.N(N_LINES), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .mask_q(mask_q), .mode_q(mode_q),
    .base_q(base_q), .eoi(eoi));

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irqm_line u_line (
      .clk(clk), .rst_n(rst_n), .irq(irq_in[g]), .level_mode(mode_q[g]),
      .clr(take[g]), .pending(pending[g]));
  end

  assign eligible = pending & ~mask_q;

  irqm_service #(.N(N_LINES), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .ack(ack_in), .eoi(eoi),
    .eligible(eligible), .base(base_q), .int_req(int_out),
    .take(take), .vec_valid(vec_valid), .vec(vec_out));

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> |(pending & ~mask_q));
endmodule

// File: tb/irq_merge8_tb_top.sv
`timescale 1ns/1ps
module irq_merge8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       ack_in;
  logic       int_out;
  logic       vec_valid;
  logic [7:0] vec_out;

  always #2 clk = ~clk;

  irq_merge8 dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ack_in(ack_in),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out));

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_mask, m_mode, m_latch, m_isr, m_lvl, m_vec;
  logic [4:0] m_base;
  logic [2:0] m_idx;
  bit         m_phase, m_vv;

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_int();
    logic [7:0] irr;
    int c, t;
    irr = (m_mode & m_lvl) | (~m_mode & m_latch);
    c = first_set(irr & ~m_mask);
    t = first_set(m_isr);
    return (c < 8) && (c < t);
  endfunction

  task automatic model_reset();
    m_mask = 8'hFF; m_mode = 8'h00; m_latch = 8'h00; m_isr = 8'h00;
    m_lvl = 8'h00; m_vec = 8'h00; m_base = 5'd0; m_idx = 3'd0;
    m_phase = 1'b0; m_vv = 1'b0;
  endtask

  task automatic model_step(logic [7:0] irq, logic wr, logic [1:0] a,
                            logic [7:0] d, logic ack);
    logic [7:0] setv, eclr, rise, irr;
    int c, t;
    bit have;
    irr  = (m_mode & m_lvl) | (~m_mode & m_latch);
    c    = first_set(irr & ~m_mask);
    t    = first_set(m_isr);
    have = (c < 8) && (c < t);
    rise = irq & ~m_lvl & ~m_mode;
    setv = 8'h00;
    eclr = 8'h00;
    m_vv = 1'b0;
    if (ack && !m_phase) begin
      if (have) setv[c] = 1'b1;
      m_idx = have ? 3'(c) : 3'd7;
      m_phase = 1'b1;
    end else if (ack) begin
      m_vv = 1'b1;
      m_vec = {m_base, m_idx};
      m_phase = 1'b0;
    end
    if (wr && a == 2'd3 && t < 8) eclr[t] = 1'b1;
    m_isr   = (m_isr & ~eclr) | setv;
    m_latch = (m_latch & ~setv) | rise;
    if (wr) begin
      case (a)
        2'd0: m_mask = d;
        2'd1: m_mode = d;
        2'd2: m_base = d[7:3];
        default: ;
      endcase
    end
    m_lvl = irq;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] irq, logic wr, logic [1:0] a,
                     logic [7:0] d, logic ack);
    irq_in = irq; reg_wr = wr; reg_addr = a; reg_wdata = d; ack_in = ack;
    @(posedge clk);
    model_step(irq, wr, a, d, ack);
    @(negedge clk);
    check("R6 int_out vs model", 32'(int_out), 32'(exp_int()));
    check("R8 vec_valid vs model", 32'(vec_valid), 32'(m_vv));
    if (m_vv) check("R8 vec_out vs model", 32'(vec_out), 32'(m_vec));
  endtask

  task automatic idle(logic [7:0] irq);
    cyc(irq, 1'b0, 2'd0, 8'h00, 1'b0);
  endtask

  task automatic wreg(logic [7:0] irq, logic [1:0] a, logic [7:0] d);
    cyc(irq, 1'b1, a, d, 1'b0);
  endtask

  task automatic ackp(logic [7:0] irq);
    cyc(irq, 1'b0, 2'd0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; ack_in = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset int_out", 32'(int_out), 32'd0);
    check("R1 reset vec_valid", 32'(vec_valid), 32'd0);

    idle(8'h08);
    idle(8'h00);
    check("R1 masked after reset", 32'(int_out), 32'd0);
    wreg(8'h00, 2'd0, 8'h00);
    check("R4 latched while masked then presented (R2)", 32'(int_out), 32'd1);
    ackp(8'h00);
    check("R7 taken request drops int_out", 32'(int_out), 32'd0);
    ackp(8'h00);
    check("R8 vec_valid", 32'(vec_valid), 32'd1);
    check("R8 vec line 3", 32'(vec_out), 32'h03);
    idle(8'h00);
    check("R8 vec_valid single cycle", 32'(vec_valid), 32'd0);
    wreg(8'h00, 2'd3, 8'h00);
    check("R7 edge latch cleared", 32'(int_out), 32'd0);

    wreg(8'h00, 2'd2, 8'hA8);
    idle(8'h24);
    check("R2 two edges pending", 32'(int_out), 32'd1);
    idle(8'h00);
    ackp(8'h00);
    check("R6 line5 blocked by line2 in service", 32'(int_out), 32'd0);
    ackp(8'h00);
    check("R5 lower line wins", 32'(vec_out), 32'hAA);
    check("R11 base from bits 7:3", 32'(vec_out[7:3]), 32'h15);
    idle(8'h02);
    check("R6 higher priority breaks through", 32'(int_out), 32'd1);
    idle(8'h00);
    ackp(8'h00);
    ackp(8'h00);
    check("R8 nested vector", 32'(vec_out), 32'hA9);
    check("R6 nested blocks line5", 32'(int_out), 32'd0);
    wreg(8'h00, 2'd3, 8'h00);
    check("R9 eoi clears line1 only", 32'(int_out), 32'd0);
    wreg(8'h00, 2'd3, 8'h00);
    check("R9 second eoi releases line5", 32'(int_out), 32'd1);
    ackp(8'h00);
    ackp(8'h00);
    check("R8 line5 vector", 32'(vec_out), 32'hAD);
    wreg(8'h00, 2'd3, 8'h00);

    wreg(8'h00, 2'd1, 8'h10);
    idle(8'h10);
    check("R3 level high pending", 32'(int_out), 32'd1);
    idle(8'h00);
    check("R3 level withdrawn", 32'(int_out), 32'd0);

    ackp(8'h00);
    ackp(8'h00);
    check("R10 spurious vector", 32'(vec_out), 32'hAF);
    check("R10 no int after spurious", 32'(int_out), 32'd0);

    cur = 8'h00;
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [7:0] flip;
      flip = 8'h00;
      for (int b = 0; b < 8; b++) if (($urandom % 10) == 0) flip[b] = 1'b1;
      cur = cur ^ flip;
      r = int'($urandom % 100);
      if (r < 15) ackp(cur);
      else if (r < 22) wreg(cur, 2'd3, 8'($urandom));
      else if (r < 25) wreg(cur, 2'd0, 8'($urandom) & 8'($urandom));
      else if (r < 27) wreg(cur, 2'd1, 8'($urandom) & 8'($urandom));
      else if (r < 28) wreg(cur, 2'd2, 8'($urandom));
      else idle(cur);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule